// File: doc/BRIEF.md
# Dual Sample FIFO with Interrupt Status

This block buffers audio samples for a playback engine in two independent byte FIFOs, FIFO A and FIFO B, each holding 1024 bytes. A byte-wide bus pushes samples while the block is in FIFO mode. In any other mode a bus write stores a byte straight into the addressed storage location. The playback side pops one byte per FIFO per strobe.

Each FIFO keeps a two-bit status: a half flag and a full/empty flag. The flags and a single level interrupt line follow fill-count thresholds, and the thresholds differ between the push and pop directions. Software collects the status of both FIFOs from one packed read that clears all flags and drops the interrupt. A clear command, or a change of operating mode, empties both FIFOs. While both FIFOs sit empty, a periodic idle interrupt keeps firing once per window of sample periods, so a driver waiting on interrupts is never starved.

Top module: `dual_sample_fifo`

## Requirements
- R1: Each FIFO stores 1024 bytes and pops them in push order. Its read and write pointers wrap modulo 1024, and order is kept across the wrap.
- R2: A bus write pushes into a FIFO only while the mode is 1 (FIFO mode). busAddr[10] selects the FIFO, 0 for A and 1 for B. In any other mode the write stores the byte at location busAddr[9:0] of the selected FIFO's storage, does not change the fill count, and can be read back through busRdAddr/busRdData.
- R3: A pop of an empty FIFO returns 0x80 and leaves the count at zero. A pop of a non-empty FIFO returns the oldest byte.
- R4: After any push or pop that changes a FIFO's count, status bit 0 (half) is 1 if the new count is 511 or less, and 0 otherwise.
- R5: A push that brings the count to exactly 512 raises the interrupt only when that FIFO's half-interrupt enable is 1. halfIeWrData bit 0 is the enable for A and bit 1 is the enable for B.
- R6: A push that brings the count to 1023 sets status bit 1 and raises the interrupt. A push at count 1024 is dropped.
- R7: A pop that brings the count to 511 raises the interrupt when the half enable is 1. A pop that brings the count to 0 sets status bit 1 and raises the interrupt.
- R8: statRdData shows FIFO A status in bits 1:0 and FIFO B status in bits 3:2. A statRdEn strobe clears both status fields and the interrupt from the next cycle on.
- R9: A clearReq strobe, or a mode write whose value differs from the current mode, zeroes both FIFOs' pointers, counts and status and drops the interrupt. A mode write of the current value changes nothing.
- R10: While both FIFOs stay empty, every 1024th sampleTick sets both status bits of both FIFOs and raises the interrupt. This repeats for as long as both FIFOs stay empty.
- R11: After reset, the counts, status and interrupt are zero, the mode is 0, and both half enables are 1.
- R12: A push and a pop to the same FIFO in the same cycle leave its count, status and interrupt unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Bus byte write strobe |
| busAddr | input | 11 | Write address: bit 10 selects the FIFO, bits 9:0 select the byte |
| busWrData | input | 8 | Write data |
| busRdAddr | input | 11 | Storage read address, laid out like busAddr |
| busRdData | output | 8 | Storage byte at busRdAddr (combinational) |
| modeWrEn | input | 1 | Mode write strobe |
| modeWrData | input | 2 | New mode; 1 selects FIFO mode |
| clearReq | input | 1 | Clear command for both FIFOs |
| halfIeWrEn | input | 1 | Half-interrupt enable write strobe |
| halfIeWrData | input | 2 | Half-interrupt enables, bit 0 for A and bit 1 for B |
| statRdEn | input | 1 | Status read strobe, clears the status |
| statRdData | output | 4 | Packed status of both FIFOs |
| popEn | input | 2 | Pop strobes, bit 0 for A and bit 1 for B |
| popDataA | output | 8 | Head byte of A, or 0x80 when A is empty |
| popDataB | output | 8 | Head byte of B, or 0x80 when B is empty |
| sampleTick | input | 1 | One pulse per sample period |
| irq | output | 1 | Level interrupt |

## Verification
Pop data and storage reads are combinational. The bench drives each strobe 1 ns after a rising edge and compares these values at the falling edge of the same cycle, before the pop takes effect. Status and interrupt come from registers and change on the rising edge that takes the strobe. The bench therefore reads them 1 ns after that edge: one cycle after a push, pop, clear or status read, and on the edge of the 1024th idle tick. A scoreboard queue per FIFO holds the bytes that should come out, and a falling-edge monitor compares every popped byte against the head of that queue.

// File: rtl/dsf_pkg.sv
package dsf_pkg;
  localparam int NUM_FIFO = 2;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_FIFO = 2'd1,
    MODE_WAVE = 2'd2,
    MODE_RSVD = 2'd3
  } fifoMode_e;

  typedef struct packed {
    logic [NUM_FIFO-1:0] push;
    logic [NUM_FIFO-1:0] pop;
    logic                dirWr;
    logic                flush;
  } dpStrobe_t;
endpackage

// File: rtl/dsf_datapath.sv
module dsf_datapath
  import dsf_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  dpStrobe_t                        strobe,
  input  logic [AW:0]                      wrAddr,
  input  logic [DATA_W-1:0]                wrData,
  input  logic [AW:0]                      rdAddr,
  output logic [DATA_W-1:0]                rdData,
  output logic [NUM_FIFO-1:0][DATA_W-1:0]  popData,
  output logic [NUM_FIFO-1:0][CW-1:0]      fillCnt
);
  localparam logic [DATA_W-1:0] SILENCE = DATA_W'(1) << (DATA_W - 1);

  logic [NUM_FIFO-1:0][DATA_W-1:0] rdWord;

  for (genvar g = 0; g < NUM_FIFO; g++) begin : g_fifo
    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wPtr;
    logic [AW-1:0]     rPtr;
    logic [CW-1:0]     cnt;

    always_ff @(posedge clk) begin
      if (strobe.push[g])
        mem[wPtr] <= wrData;
      else if (strobe.dirWr && (wrAddr[AW] == 1'(g)))
        mem[wrAddr[AW-1:0]] <= wrData;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        wPtr <= '0;
        rPtr <= '0;
        cnt  <= '0;
      end else if (strobe.flush) begin
        wPtr <= '0;
        rPtr <= '0;
        cnt  <= '0;
      end else begin
        if (strobe.push[g]) wPtr <= wPtr + 1'b1;
        if (strobe.pop[g])  rPtr <= rPtr + 1'b1;
        case ({strobe.push[g], strobe.pop[g]})
          2'b10:   cnt <= cnt + 1'b1;
          2'b01:   cnt <= cnt - 1'b1;
          default: cnt <= cnt;
        endcase
      end
    end

    assign popData[g] = (cnt == '0) ? SILENCE : mem[rPtr];
    assign fillCnt[g] = cnt;
    assign rdWord[g]  = mem[rdAddr[AW-1:0]];

    AST_PTR_TRACKS_COUNT: assert property (@(posedge clk) disable iff (!rstN)
      AW'(wPtr - rPtr) == cnt[AW-1:0]); // R1
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
      cnt <= CW'(DEPTH)); // R6
  end

  assign rdData = rdWord[rdAddr[AW]];
endmodule

// File: rtl/dsf_ctrl.sv
module dsf_ctrl
  import dsf_pkg::*;
#(
  parameter int DEPTH      = 1024,
  parameter int IDLE_TICKS = 1024,
  localparam int AW        = $clog2(DEPTH),
  localparam int CW        = AW + 1,
  localparam int HALF      = DEPTH / 2,
  localparam int IW        = $clog2(IDLE_TICKS)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        busWrEn,
  input  logic                        busSel,
  input  logic                        modeWrEn,
  input  logic [1:0]                  modeWrData,
  input  logic                        clearReq,
  input  logic                        halfIeWrEn,
  input  logic [NUM_FIFO-1:0]         halfIeWrData,
  input  logic                        statRdEn,
  input  logic [NUM_FIFO-1:0]         popEn,
  input  logic                        sampleTick,
  input  logic [NUM_FIFO-1:0][CW-1:0] fillCnt,
  output dpStrobe_t                   strobe,
  output logic [2*NUM_FIFO-1:0]       statRdData,
  output logic                        irq
);
  fifoMode_e                   modeR;
  logic [NUM_FIFO-1:0]         halfIeR;
  logic [NUM_FIFO-1:0][1:0]    statR;
  logic [NUM_FIFO-1:0][1:0]    statNext;
  logic                        irqR;
  logic [IW-1:0]               idleCnt;

  logic                        flushNow;
  logic                        fifoMode;
  logic [NUM_FIFO-1:0]         pushGo;
  logic [NUM_FIFO-1:0]         popGo;
  logic [NUM_FIFO-1:0]         raise;
  logic [NUM_FIFO-1:0]         isEmpty;
  logic                        bothEmpty;
  logic                        idleFire;

  assign fifoMode  = (modeR == MODE_FIFO);
  assign flushNow  = clearReq || (modeWrEn && (modeWrData != modeR));
  assign bothEmpty = &isEmpty;
  assign idleFire  = bothEmpty && sampleTick && (idleCnt == IW'(IDLE_TICKS - 1));

  for (genvar g = 0; g < NUM_FIFO; g++) begin : g_stat
    logic [CW-1:0] afterCnt;
    logic          pushOnly;
    logic          popOnly;
    logic          hitEdge;
    logic          hitHalf;
    logic [1:0]    nxt;

    assign isEmpty[g] = (fillCnt[g] == '0);
    assign pushGo[g]  = !flushNow && busWrEn && fifoMode && (busSel == 1'(g))
                        && (fillCnt[g] < CW'(DEPTH));
    assign popGo[g]   = !flushNow && popEn[g] && !isEmpty[g];
    assign pushOnly   = pushGo[g] && !popGo[g];
    assign popOnly    = popGo[g] && !pushGo[g];

    always_comb begin
      afterCnt = fillCnt[g];
      if (pushOnly)     afterCnt = fillCnt[g] + 1'b1;
      else if (popOnly) afterCnt = fillCnt[g] - 1'b1;
      hitEdge = (pushOnly && (afterCnt == CW'(DEPTH - 1)))
             || (popOnly && (afterCnt == '0));
      hitHalf = halfIeR[g] && ((pushOnly && (afterCnt == CW'(HALF)))
             || (popOnly && (afterCnt == CW'(HALF - 1))));
      nxt = statRdEn ? 2'b00 : statR[g];
      if (pushOnly || popOnly) begin
        nxt[0] = (afterCnt <= CW'(HALF - 1));
        nxt[1] = nxt[1] | hitEdge;
      end
      if (idleFire) nxt = 2'b11;
      if (flushNow) nxt = 2'b00;
    end

    assign statNext[g] = nxt;
    assign raise[g]    = hitEdge || hitHalf;

    AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
      (popEn[g] && isEmpty[g] && !pushGo[g] && !flushNow) |=> (fillCnt[g] == '0)); // R3
    AST_FULL_PUSH_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
      (busWrEn && fifoMode && (busSel == 1'(g)) && (fillCnt[g] == CW'(DEPTH))
       && !popGo[g] && !flushNow) |=> (fillCnt[g] == CW'(DEPTH))); // R6
    AST_DRAIN_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
      (popGo[g] && !pushGo[g] && (fillCnt[g] == CW'(1))) |=> (statR[g][1] && irq)); // R7
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeR   <= MODE_OFF;
      halfIeR <= '1;
      statR   <= '0;
      irqR    <= 1'b0;
      idleCnt <= '0;
    end else begin
      if (modeWrEn)   modeR   <= fifoMode_e'(modeWrData);
      if (halfIeWrEn) halfIeR <= halfIeWrData;
      statR <= statNext;
      if (flushNow)
        irqR <= 1'b0;
      else
        irqR <= (statRdEn ? 1'b0 : irqR) | (|raise) | idleFire;
      if (flushNow || !bothEmpty || idleFire)
        idleCnt <= '0;
      else if (sampleTick)
        idleCnt <= idleCnt + 1'b1;
    end
  end

  assign strobe     = '{push: pushGo, pop: popGo, dirWr: busWrEn && !fifoMode && !flushNow,
                        flush: flushNow};
  assign statRdData = statR;
  assign irq        = irqR;

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    flushNow |=> (!irq && (statR == '0) && (fillCnt == '0))); // R9
endmodule

// File: rtl/dual_sample_fifo.sv
module dual_sample_fifo
  import dsf_pkg::*;
#(
  parameter int DEPTH      = 1024,
  parameter int DATA_W     = 8,
  parameter int IDLE_TICKS = 1024,
  localparam int AW        = $clog2(DEPTH),
  localparam int CW        = AW + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [AW:0]       busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [AW:0]       busRdAddr,
  output logic [DATA_W-1:0] busRdData,
  input  logic              modeWrEn,
  input  logic [1:0]        modeWrData,
  input  logic              clearReq,
  input  logic              halfIeWrEn,
  input  logic [1:0]        halfIeWrData,
  input  logic              statRdEn,
  output logic [3:0]        statRdData,
  input  logic [1:0]        popEn,
  output logic [DATA_W-1:0] popDataA,
  output logic [DATA_W-1:0] popDataB,
  input  logic              sampleTick,
  output logic              irq
);
  dpStrobe_t                       strobe;
  logic [NUM_FIFO-1:0][CW-1:0]     fillCnt;
  logic [NUM_FIFO-1:0][DATA_W-1:0] popData;

  dsf_ctrl #(.DEPTH(DEPTH), .IDLE_TICKS(IDLE_TICKS)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .busWrEn      (busWrEn),
    .busSel       (busAddr[AW]),
    .modeWrEn     (modeWrEn),
    .modeWrData   (modeWrData),
    .clearReq     (clearReq),
    .halfIeWrEn   (halfIeWrEn),
    .halfIeWrData (halfIeWrData),
    .statRdEn     (statRdEn),
    .popEn        (popEn),
    .sampleTick   (sampleTick),
    .fillCnt      (fillCnt),
    .strobe       (strobe),
    .statRdData   (statRdData),
    .irq          (irq)
  );

  dsf_datapath #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrAddr  (busAddr),
    .wrData  (busWrData),
    .rdAddr  (busRdAddr),
    .rdData  (busRdData),
    .popData (popData),
    .fillCnt (fillCnt)
  );

  assign popDataA = popData[0];
  assign popDataB = popData[1];
endmodule

// File: tb/dual_sample_fifo_bench.sv
module dual_sample_fifo_bench;
  localparam int DEPTH = 1024;
  localparam int AW    = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [AW:0] busAddr = '0;
  logic [7:0]  busWrData = '0;
  logic [AW:0] busRdAddr = '0;
  logic [7:0]  busRdData;
  logic        modeWrEn = 1'b0;
  logic [1:0]  modeWrData = '0;
  logic        clearReq = 1'b0;
  logic        halfIeWrEn = 1'b0;
  logic [1:0]  halfIeWrData = '0;
  logic        statRdEn = 1'b0;
  logic [3:0]  statRdData;
  logic [1:0]  popEn = '0;
  logic [7:0]  popDataA;
  logic [7:0]  popDataB;
  logic        sampleTick = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int curMode = 0;
  logic [7:0] qA[$];
  logic [7:0] qB[$];

  always #4 clk = ~clk;

  dual_sample_fifo u_dual_sample_fifo (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdAddr(busRdAddr), .busRdData(busRdData),
    .modeWrEn(modeWrEn), .modeWrData(modeWrData), .clearReq(clearReq),
    .halfIeWrEn(halfIeWrEn), .halfIeWrData(halfIeWrData), .statRdEn(statRdEn),
    .statRdData(statRdData), .popEn(popEn), .popDataA(popDataA),
    .popDataB(popDataB), .sampleTick(sampleTick), .irq(irq)
  );

  task automatic ck(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Monitor: compares each popped byte with the scoreboard head
  always @(negedge clk) begin
    logic [7:0] expA;
    logic [7:0] expB;
    if (popEn[0]) begin
      if (qA.size() == 0) ck("R3 A empty pop", popDataA, 8'h80);
      else begin expA = qA.pop_front(); ck("R1 A order", popDataA, expA); end
    end
    if (popEn[1]) begin
      if (qB.size() == 0) ck("R3 B empty pop", popDataB, 8'h80);
      else begin expB = qB.pop_front(); ck("R1 B order", popDataB, expB); end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic push(int f, logic [7:0] d);
    busAddr = '0; busAddr[AW] = f[0]; busWrData = d; busWrEn = 1'b1;
    step();
    busWrEn = 1'b0;
    if (f == 0) begin if (qA.size() < DEPTH) qA.push_back(d); end
    else begin if (qB.size() < DEPTH) qB.push_back(d); end
  endtask

  task automatic pop(int f);
    popEn[f] = 1'b1;
    step();
    popEn = '0;
  endtask

  task automatic pushPop(int f, logic [7:0] d);
    busAddr = '0; busAddr[AW] = f[0]; busWrData = d; busWrEn = 1'b1; popEn[f] = 1'b1;
    step();
    busWrEn = 1'b0; popEn = '0;
    if (f == 0) qA.push_back(d); else qB.push_back(d);
  endtask

  task automatic writeRaw(logic sel, logic [AW-1:0] a, logic [7:0] d);
    busAddr = {sel, a}; busWrData = d; busWrEn = 1'b1;
    step();
    busWrEn = 1'b0;
  endtask

  task automatic readRaw(logic sel, logic [AW-1:0] a, output logic [7:0] v);
    busRdAddr = {sel, a};
    #1 v = busRdData;
  endtask

  task automatic setMode(int m);
    modeWrData = 2'(m); modeWrEn = 1'b1;
    step();
    modeWrEn = 1'b0;
    if (m != curMode) begin qA.delete(); qB.delete(); end
    curMode = m;
  endtask

  task automatic rdStat(output logic [3:0] v);
    statRdEn = 1'b1;
    #1 v = statRdData;
    step();
    statRdEn = 1'b0;
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finishRun();
    end
  end

  initial begin
    logic [3:0] s;
    logic [7:0] v;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    step();
    ck("R11 reset irq", irq, 0);
    ck("R11 reset status", statRdData, 4'h0);

    // Direct writes in mode 0
    writeRaw(1'b0, 10'd5, 8'h3C);
    writeRaw(1'b1, 10'd7, 8'h5A);
    readRaw(1'b0, 10'd5, v); ck("R2 direct write A", v, 8'h3C);
    readRaw(1'b1, 10'd7, v); ck("R2 direct write B", v, 8'h5A);
    ck("R2 direct write not queued", popDataA, 8'h80);

    setMode(1);
    ck("R9 mode change irq low", irq, 0);
    push(0, 8'h11); push(0, 8'h22); push(0, 8'h33);
    ck("R4 half after push", statRdData, 4'b0001);
    ck("R4 no irq on small push", irq, 0);
    rdStat(s);
    ck("R8 read returns packed status", s, 4'b0001);
    ck("R8 status cleared", statRdData, 4'h0);
    repeat (4) pop(0);
    ck("R7 drain to zero status", statRdData, 4'b0011);
    ck("R7 drain to zero irq", irq, 1);
    rdStat(s);
    ck("R8 irq cleared by read", irq, 0);
    ck("R8 status cleared after drain", statRdData, 4'h0);

    // Half threshold on B with enable set (reset default)
    for (int i = 0; i < 511; i++) push(1, 8'(i));
    ck("R4 B half below 512", statRdData, 4'b0100);
    ck("R5 no irq below 512", irq, 0);
    push(1, 8'hA5);
    ck("R5 irq at 512 enabled", irq, 1);
    ck("R4 half cleared at 512", statRdData, 4'b0000);
    rdStat(s);
    pushPop(1, 8'hC3);
    ck("R12 push+pop irq", irq, 0);
    ck("R12 push+pop status", statRdData, 4'h0);
    pop(1);
    ck("R7 irq at 511 enabled", irq, 1);
    clearReq = 1'b1; step(); clearReq = 1'b0; qA.delete(); qB.delete();
    ck("R9 clear drops irq", irq, 0);
    ck("R9 clear zeroes status", statRdData, 4'h0);
    pop(1);

    // Same-mode write keeps contents
    push(0, 8'h55);
    setMode(1);
    #1 ck("R9 same mode keeps data", popDataA, 8'h55);
    pop(0);
    rdStat(s);

    // Disabled half interrupt on B, fill to full
    halfIeWrData = 2'b01; halfIeWrEn = 1'b1; step(); halfIeWrEn = 1'b0;
    for (int i = 0; i < 512; i++) push(1, 8'(i * 3));
    ck("R5 no irq at 512 disabled", irq, 0);
    for (int i = 512; i < 1023; i++) push(1, 8'(i * 3));
    ck("R6 irq at 1023", irq, 1);
    ck("R6 full flag at 1023", statRdData, 4'b1000);
    rdStat(s);
    push(1, 8'hE1);
    ck("R6 no event at 1024", irq, 0);
    push(1, 8'hE2);
    ck("R6 push to full no event", statRdData, 4'h0);
    for (int i = 0; i < 513; i++) pop(1);
    ck("R7 no irq at 511 disabled", irq, 0);
    ck("R4 half set at 511", statRdData, 4'b0100);
    for (int i = 0; i < 511; i++) pop(1);
    ck("R7 irq at empty", irq, 1);
    pop(1);
    rdStat(s);
    for (int i = 0; i < 3; i++) push(1, 8'hF0 + 8'(i));
    for (int i = 0; i < 3; i++) pop(1);
    rdStat(s);

    // Mode change flushes, direct write in mode 2
    push(0, 8'h66);
    setMode(2);
    #1 ck("R9 mode change flushes", popDataA, 8'h80);
    writeRaw(1'b0, 10'd3, 8'h99);
    readRaw(1'b0, 10'd3, v); ck("R2 direct write mode 2", v, 8'h99);
    ck("R2 mode 2 write not queued", popDataA, 8'h80);

    // Idle interrupt
    setMode(1);
    rdStat(s);
    sampleTick = 1'b1;
    repeat (1023) @(posedge clk);
    #1 ck("R10 no idle irq before window", irq, 0);
    step();
    sampleTick = 1'b0;
    ck("R10 idle irq", irq, 1);
    ck("R10 idle status all set", statRdData, 4'b1111);
    rdStat(s);
    ck("R8 idle status read", s, 4'b1111);
    sampleTick = 1'b1;
    repeat (1023) @(posedge clk);
    #1 ck("R10 repeat not early", irq, 0);
    step();
    sampleTick = 1'b0;
    ck("R10 idle irq repeats", irq, 1);

    done = 1;
    finishRun();
  end
endmodule